// File: doc/BRIEF.md
# Microword Rule Checker

This block sits beside the control store of a single-bus microcoded datapath. It watches every control word as it is issued and reports microprograms that break the bus and memory rules. It does not look at data values. Each microword carries six bus-driver switches, eight bus-load switches, an ALU function field and a memory function field. The checker decodes these fields together with its own record of whether a memory read is still outstanding. It also does not block or fix the offending step. It only records what it saw.

Each rule has its own sticky flag. The checker also keeps the micro-address and a 4-bit code for the first violating step. Both remain until software or a test sequencer pulses the synchronous clear. A control word is judged only when the step strobe is high. Cycles in which the sequencer is stalled on a memory wait therefore add nothing.

Top module: `mw_rule_checker`

## Requirements
- R1: A judged step with two or more bits of `drv_i` set sets `err_o[0]` (bus contention). The `drv_i` bits are: 0 instruction address field, 1 ALU result, 2 PC, 3 R1, 4 R2, 5 MBR.
- R2: A judged step with any `ld_i` bit set while `drv_i` is zero sets `err_o[1]` (load from an undriven bus). The `ld_i` bits are: 0 IR, 1 ALU input, 2 operand, 3 PC, 4 R1, 5 R2, 6 MAR, 7 MBR.
- R3: A judged step that drives the MBR (`drv_i[5]`) while a read is outstanding sets `err_o[2]`. A read becomes outstanding at the end of its own step, so a step that both issues the read and drives the MBR is legal.
- R4: A judged step with a nonzero `alu_fn_i` (1 add, 2 sub, 3 inc, 4 dec) while `ld_i[1]` is clear sets `err_o[3]`.
- R5: The memory field is encoded 0 idle, 1 read, 2 write, 3 wait. A judged read makes a read outstanding. A judged wait clears it. A judged read or write issued while a read is outstanding sets `err_o[4]`, and the read stays outstanding.
- R6: When `step_i` is low, the inputs have no effect: no flag, no first record and no outstanding-read change.
- R7: Flags are sticky. Each stays set until a cycle with `clear_i` high, which zeroes all flags and the first record (`first_vld_o`, `first_addr_o`, `first_code_o`).
- R8: The first violating step after reset or clear sets `first_vld_o` and captures `uaddr_i` into `first_addr_o`. It captures into `first_code_o` the code of the lowest-numbered rule it broke: 1 contention, 2 undriven load, 3 early MBR, 4 ALU without input, 5 memory overlap. Later violations leave the record unchanged.
- R9: A judged violating step in the same cycle as `clear_i` is recorded as the new first violation, and its flags are kept.
- R10: After reset, all flags, `first_vld_o`, `first_addr_o` and `first_code_o` are zero, and no read is outstanding.
- R11: `clear_i` does not change the outstanding-read state.
- R12: All outputs are registered. A step judged at one clock edge shows in the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of flags and first record |
| step_i | input | 1 | High when the presented microword is issued |
| uaddr_i | input | 8 | Micro-address of the presented microword |
| drv_i | input | 6 | Bus-driver switches |
| ld_i | input | 8 | Bus-load switches |
| alu_fn_i | input | 3 | ALU function, 0 means none |
| mem_fn_i | input | 2 | Memory function |
| err_o | output | 5 | Sticky per-rule flags |
| first_vld_o | output | 1 | First record valid |
| first_addr_o | output | 8 | Micro-address of first violation |
| first_code_o | output | 4 | Rule code of first violation |

## Verification
Clearing the log and capturing a new violation can fall in the same cycle. The bench provokes this by pulsing `clear_i` with a judged step that both contends the bus and issues a read while one is outstanding. The flags and first record are already set from earlier violations when this happens. Afterwards the outputs must hold only the new step's flags and its own address and code, with nothing left over from before the clear. A second overlap is one step judged under several rules at once. There the code must name the lowest-numbered rule while every broken rule's flag is set.

// File: rtl/mw_chk_pkg.sv
package mw_chk_pkg;
  localparam int unsigned NRULE  = 5;
  localparam int unsigned CODE_W = 4;

  typedef enum logic [1:0] {
    MEM_IDLE  = 2'd0,
    MEM_READ  = 2'd1,
    MEM_WRITE = 2'd2,
    MEM_WAIT  = 2'd3
  } mem_fn_e;

  // rule index into the flag vector; code reported = index + 1
  typedef enum int unsigned {
    RULE_CONTEND = 0,
    RULE_FLOAT   = 1,
    RULE_MBR_EARLY = 2,
    RULE_ALU_NOIN  = 3,
    RULE_MEM_OVLP  = 4
  } rule_e;
endpackage

// File: rtl/mw_rule_eval.sv
module mw_rule_eval
  import mw_chk_pkg::*;
#(
  parameter int unsigned NDRV    = 6,
  parameter int unsigned NLD     = 8,
  parameter int unsigned AF_W    = 3,
  parameter int unsigned MBR_DRV = 5,
  parameter int unsigned ALU_LD  = 1
) (
  input  logic [NDRV-1:0]  drv_i,
  input  logic [NLD-1:0]   ld_i,
  input  logic [AF_W-1:0]  alu_fn_i,
  input  logic [1:0]       mem_fn_i,
  input  logic             pend_i,
  output logic [NRULE-1:0] viol_o
);
  logic [NDRV-1:0] seen;
  logic [NDRV-1:0] multi;

  // running "one seen" / "two seen" chain
  assign seen[0]  = drv_i[0];
  assign multi[0] = 1'b0;
  for (genvar g = 1; g < NDRV; g++) begin : g_pop
    assign seen[g]  = seen[g-1] | drv_i[g];
    assign multi[g] = multi[g-1] | (seen[g-1] & drv_i[g]);
  end

  mem_fn_e mem;
  assign mem = mem_fn_e'(mem_fn_i);

  always_comb begin
    viol_o                 = '0;
    viol_o[RULE_CONTEND]   = multi[NDRV-1];
    viol_o[RULE_FLOAT]     = (|ld_i) && !seen[NDRV-1];
    viol_o[RULE_MBR_EARLY] = drv_i[MBR_DRV] && pend_i;
    viol_o[RULE_ALU_NOIN]  = (|alu_fn_i) && !ld_i[ALU_LD];
    viol_o[RULE_MEM_OVLP]  = pend_i && ((mem == MEM_READ) || (mem == MEM_WRITE));
  end
endmodule

// File: rtl/mw_read_track.sv
module mw_read_track
  import mw_chk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [1:0] mem_fn_i,
  output logic       pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
    end else if (step_i) begin
      if (mem_fn_i == MEM_READ)      pend_o <= 1'b1;
      else if (mem_fn_i == MEM_WAIT) pend_o <= 1'b0;
    end
  end

  a_r5_wait_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mem_fn_i == MEM_WAIT) |=> !pend_o);
  a_r5_read_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && mem_fn_i == MEM_READ) |=> pend_o);
endmodule

// File: rtl/mw_err_log.sv
module mw_err_log
  import mw_chk_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [AW-1:0]     uaddr_i,
  input  logic [NRULE-1:0]  viol_i,
  output logic [NRULE-1:0]  err_o,
  output logic              first_vld_o,
  output logic [AW-1:0]     first_addr_o,
  output logic [CODE_W-1:0] first_code_o
);
  logic [NRULE-1:0]  hit;
  logic [NRULE-1:0]  base_err;
  logic              base_vld;
  logic [CODE_W-1:0] enc;

  assign hit      = step_i ? viol_i : '0;
  assign base_err = clear_i ? '0 : err_o;
  assign base_vld = clear_i ? 1'b0 : first_vld_o;

  // lowest-numbered rule wins
  always_comb begin
    enc = '0;
    for (int i = NRULE - 1; i >= 0; i--) begin
      if (hit[i]) enc = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o        <= '0;
      first_vld_o  <= 1'b0;
      first_addr_o <= '0;
      first_code_o <= '0;
    end else begin
      err_o <= base_err | hit;
      if (|hit && !base_vld) begin
        first_vld_o  <= 1'b1;
        first_addr_o <= uaddr_i;
        first_code_o <= enc;
      end else if (clear_i) begin
        first_vld_o  <= 1'b0;
        first_addr_o <= '0;
        first_code_o <= '0;
      end
    end
  end

  a_r8_first_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (first_vld_o && !clear_i) |=> (first_vld_o && $stable(first_addr_o) && $stable(first_code_o)));
  a_r8_code_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_vld_o |-> (first_code_o >= 1 && first_code_o <= CODE_W'(NRULE)));
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((err_o & $past(err_o)) == $past(err_o)));
  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !step_i) |=> (err_o == '0 && !first_vld_o));
endmodule

// File: rtl/mw_rule_checker.sv
module mw_rule_checker
  import mw_chk_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned NDRV    = 6,
  parameter int unsigned NLD     = 8,
  parameter int unsigned AF_W    = 3,
  parameter int unsigned MBR_DRV = 5,
  parameter int unsigned ALU_LD  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [AW-1:0]     uaddr_i,
  input  logic [NDRV-1:0]   drv_i,
  input  logic [NLD-1:0]    ld_i,
  input  logic [AF_W-1:0]   alu_fn_i,
  input  logic [1:0]        mem_fn_i,
  output logic [NRULE-1:0]  err_o,
  output logic              first_vld_o,
  output logic [AW-1:0]     first_addr_o,
  output logic [CODE_W-1:0] first_code_o
);
  logic             pend;
  logic [NRULE-1:0] viol;

  mw_read_track i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .mem_fn_i (mem_fn_i),
    .pend_o   (pend)
  );

  mw_rule_eval #(
    .NDRV    (NDRV),
    .NLD     (NLD),
    .AF_W    (AF_W),
    .MBR_DRV (MBR_DRV),
    .ALU_LD  (ALU_LD)
  ) i_eval (
    .drv_i    (drv_i),
    .ld_i     (ld_i),
    .alu_fn_i (alu_fn_i),
    .mem_fn_i (mem_fn_i),
    .pend_i   (pend),
    .viol_o   (viol)
  );

  mw_err_log #(.AW(AW)) i_log (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (clear_i),
    .step_i       (step_i),
    .uaddr_i      (uaddr_i),
    .viol_i       (viol),
    .err_o        (err_o),
    .first_vld_o  (first_vld_o),
    .first_addr_o (first_addr_o),
    .first_code_o (first_code_o)
  );

  a_r1_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && $countones(drv_i) > 1) |=> err_o[RULE_CONTEND]);
  a_r2_float_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && |ld_i && drv_i == '0) |=> err_o[RULE_FLOAT]);
  a_r4_alu_noin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && |alu_fn_i && !ld_i[ALU_LD]) |=> err_o[RULE_ALU_NOIN]);
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clear_i) |=> ($stable(err_o) && $stable(first_vld_o) && $stable(first_addr_o)));
  a_r3_early_mbr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && drv_i[MBR_DRV] && pend) |=> err_o[RULE_MBR_EARLY]);
endmodule

// File: tb/test_mw_rule_checker.sv
`timescale 1ns/1ps
module test_mw_rule_checker;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clear_i = 1'b0;
  logic       step_i = 1'b0;
  logic [7:0] uaddr_i = '0;
  logic [5:0] drv_i = '0;
  logic [7:0] ld_i = '0;
  logic [2:0] alu_fn_i = '0;
  logic [1:0] mem_fn_i = '0;
  logic [4:0] err_o;
  logic       first_vld_o;
  logic [7:0] first_addr_o;
  logic [3:0] first_code_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  mw_rule_checker i_mw_rule_checker (.*);

  typedef struct {
    logic [4:0] flags;
    logic       vld;
    logic [7:0] addr;
    logic [3:0] code;
    string      rq;
  } exp_t;

  exp_t q[$];

  // reference state
  logic [4:0] m_flags = '0;
  logic       m_vld = 1'b0;
  logic [7:0] m_addr = '0;
  logic [3:0] m_code = '0;
  logic       m_pend = 1'b0;

  task automatic cyc(input bit st, input bit clr, input logic [7:0] ad,
                     input logic [5:0] d, input logic [7:0] l,
                     input logic [2:0] a, input logic [1:0] m, input string rq);
    logic [4:0] v;
    exp_t e;
    @(negedge clk_i);
    step_i = st; clear_i = clr; uaddr_i = ad;
    drv_i = d; ld_i = l; alu_fn_i = a; mem_fn_i = m;
    v = '0;
    if (st) begin
      v[0] = $countones(d) >= 2;
      v[1] = (l != 0) && (d == 0);
      v[2] = d[5] && m_pend;
      v[3] = (a != 0) && !l[1];
      v[4] = m_pend && (m == 2'd1 || m == 2'd2);
    end
    if (clr) begin
      m_flags = '0; m_vld = 1'b0; m_addr = '0; m_code = '0;
    end
    m_flags = m_flags | v;
    if (v != 0 && !m_vld) begin
      m_vld = 1'b1; m_addr = ad;
      m_code = v[0] ? 4'd1 : v[1] ? 4'd2 : v[2] ? 4'd3 : v[3] ? 4'd4 : 4'd5;
    end
    if (st) begin
      if (m == 2'd1) m_pend = 1'b1;
      else if (m == 2'd3) m_pend = 1'b0;
    end
    e.flags = m_flags; e.vld = m_vld; e.addr = m_addr; e.code = m_code; e.rq = rq;
    q.push_back(e);
  endtask

  // monitor: outputs settle after the posedge that judged the pushed word
  initial begin
    forever begin
      exp_t e;
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (err_o !== e.flags || first_vld_o !== e.vld ||
            first_addr_o !== e.addr || first_code_o !== e.code) begin
          errors++;
          $display("FAIL %s: got flags=%b vld=%b addr=%0d code=%0d exp flags=%b vld=%b addr=%0d code=%0d",
                   e.rq, err_o, first_vld_o, first_addr_o, first_code_o,
                   e.flags, e.vld, e.addr, e.code);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: got hang exp completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (err_o !== 5'b0 || first_vld_o !== 1'b0 || first_addr_o !== 8'd0 || first_code_o !== 4'd0) begin
      errors++;
      $display("FAIL R10: got flags=%b vld=%b addr=%0d code=%0d exp all zero",
               err_o, first_vld_o, first_addr_o, first_code_o);
    end
    rst_ni = 1'b1;
    // legal fetch: PC->MAR+ALU inc read; result->PC wait; MBR->IR (R12, R3 legal path)
    cyc(1, 0, 8'd1, 6'b000100, 8'b01000010, 3'd3, 2'd1, "R12 fetch1");
    cyc(1, 0, 8'd2, 6'b000010, 8'b00001000, 3'd0, 2'd3, "R5 wait");
    cyc(1, 0, 8'd3, 6'b100000, 8'b00000001, 3'd0, 2'd0, "R3 legal MBR");
    // read step that also drives MBR is legal, then wait
    cyc(1, 0, 8'd4, 6'b100000, 8'b01000000, 3'd0, 2'd1, "R3 same-step read");
    cyc(1, 0, 8'd5, 6'b000000, 8'b00000000, 3'd0, 2'd3, "R5 wait idle");
    // contention
    cyc(1, 0, 8'd10, 6'b011000, 8'b00000100, 3'd0, 2'd0, "R1 contention");
    cyc(1, 0, 8'd11, 6'b000000, 8'b00010000, 3'd0, 2'd0, "R2 float, R8 first held");
    cyc(0, 0, 8'd12, 6'b111111, 8'b00000000, 3'd1, 2'd1, "R6 stalled ignored");
    cyc(0, 1, 8'd0, 6'b0, 8'b0, 3'd0, 2'd0, "R7 clear");
    // multiple rules in one step: code is lowest
    cyc(1, 0, 8'd20, 6'b000110, 8'b00000100, 3'd2, 2'd0, "R8 multi rule");
    cyc(1, 0, 8'd21, 6'b000001, 8'b00000010, 3'd1, 2'd0, "R4 alu with input ok");
    cyc(0, 1, 8'd0, 6'b0, 8'b0, 3'd0, 2'd0, "R7 clear2");
    cyc(1, 0, 8'd22, 6'b001000, 8'b00000000, 3'd4, 2'd0, "R4 alu no input");
    cyc(0, 1, 8'd0, 6'b0, 8'b0, 3'd0, 2'd0, "R7 clear3");
    // early MBR
    cyc(1, 0, 8'd30, 6'b000100, 8'b01000000, 3'd0, 2'd1, "R5 read issue");
    cyc(1, 0, 8'd31, 6'b100000, 8'b00000001, 3'd0, 2'd0, "R3 early MBR");
    cyc(0, 1, 8'd0, 6'b0, 8'b0, 3'd0, 2'd0, "R11 clear keeps pending");
    cyc(1, 0, 8'd32, 6'b100000, 8'b00010000, 3'd0, 2'd0, "R11 still pending");
    cyc(1, 0, 8'd33, 6'b100000, 8'b00000001, 3'd0, 2'd3, "R3 MBR in wait step");
    cyc(1, 0, 8'd34, 6'b100000, 8'b00000001, 3'd0, 2'd0, "R5 after wait clean");
    cyc(0, 1, 8'd0, 6'b0, 8'b0, 3'd0, 2'd0, "R7 clear4");
    cyc(1, 0, 8'd35, 6'b100000, 8'b00000001, 3'd0, 2'd0, "R5 pending gone");
    // overlap
    cyc(1, 0, 8'd40, 6'b000100, 8'b01000000, 3'd0, 2'd1, "R5 read");
    cyc(1, 0, 8'd41, 6'b000100, 8'b01000000, 3'd0, 2'd1, "R5 second read");
    cyc(1, 0, 8'd42, 6'b000000, 8'b00000000, 3'd0, 2'd2, "R5 write pending");
    cyc(0, 0, 8'd43, 6'b000000, 8'b00000000, 3'd0, 2'd3, "R6 stalled wait ignored");
    // clear with violation same cycle
    cyc(1, 1, 8'd44, 6'b110000, 8'b00000010, 3'd0, 2'd1, "R9 clear+violation");
    cyc(1, 0, 8'd45, 6'b000000, 8'b00000000, 3'd0, 2'd3, "R9 record kept");
    cyc(1, 0, 8'd46, 6'b000000, 8'b00000000, 3'd0, 2'd2, "R5 write no pending");
    cyc(0, 0, 8'd0, 6'b0, 8'b0, 3'd0, 2'd0, "R7 hold");
    repeat (3) @(negedge clk_i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule